// File: doc/BRIEF.md
# Monitor Entry Controller

After a power-on reset, this block decides whether a small microcontroller core starts in its serial monitor mode, and which clocking and watchdog settings apply. It waits for its input synchronizers to fill and then takes one snapshot of the IRQ pin level and of two high-voltage detector flags, one for the IRQ pin and one for the RST pin. It then fetches the two reset-vector bytes over a simple request/valid read port, high address first. From the snapshot and the vector it selects one of three entry conditions, or normal start-up.

A high voltage on IRQ at the snapshot always selects monitor entry with the oscillator driving the bus directly. A blank vector (both bytes all ones) with no high voltage also selects monitor entry. In that case the PLL is enabled only when IRQ was low, so that a 32.768 kHz crystal is stepped up by a factor of 75 to 2.4576 MHz. For the two blank-vector conditions, the block also asks the chip for one extra internal reset pulse. The selected mode is latched and held until the next power-on reset; the extra reset does not clear it. In the high-voltage condition, the watchdog disable follows the live high-voltage flags on either pin.

Top module: `mon_entry_ctrl`

## Requirements
- R1: After power-on reset release the block performs exactly two reads, address 0xFFFE first and then 0xFFFF. `mem_req_o` and `mem_addr_o` hold steady until `mem_valid_i` is seen, and no request is made once the decision is taken.
- R2: The vector counts as blank only when both bytes read 0xFF. A single 0xFF byte counts as not blank.
- R3: High voltage on IRQ at the snapshot gives `mon_en_o`=1, `pll_en_o`=0 and `portb_chk_o`=1, with no secondary reset, whatever the vector holds.
- R4: With no IRQ high voltage, a blank vector and IRQ high gives `mon_en_o`=1, `pll_en_o`=0 and `portb_chk_o`=0.
- R5: With no IRQ high voltage, a blank vector and IRQ low gives `mon_en_o`=1, `pll_en_o`=1 and `portb_chk_o`=0.
- R6: With no IRQ high voltage and a non-blank vector, all of `mon_en_o`, `pll_en_o`, `cop_dis_o`, `portb_chk_o` and `sec_rst_o` stay 0. The PLL is never enabled with a non-blank vector.
- R7: In the R4 and R5 cases, `sec_rst_o` makes exactly one pulse, SEC_RST_CYCLES (default 4) clock cycles long, after the decision.
- R8: In the R4 and R5 cases, `cop_dis_o` is 1 whatever the later levels of IRQ, IRQ high voltage or RST high voltage.
- R9: In the R3 case, `cop_dis_o` equals the OR of the IRQ and RST high-voltage flags, seen through the SYNC_STAGES-flop synchronizer. Moving the high voltage from IRQ to RST keeps the watchdog disabled.
- R10: `mon_en_o`, `pll_en_o` and `portb_chk_o` do not change after the decision, whatever the inputs do, until the next power-on reset.
- R11: While `por_n` is low, and after its release until the decision, all five control outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| irq_pin_i | input | 1 | IRQ pin logic level (asynchronous) |
| irq_hv_i | input | 1 | High voltage detected on IRQ (asynchronous) |
| rst_hv_i | input | 1 | High voltage detected on RST (asynchronous) |
| mem_req_o | output | 1 | Vector byte read request |
| mem_addr_o | output | ADDR_W (16) | Read address |
| mem_data_i | input | DATA_W (8) | Read data, valid with mem_valid_i |
| mem_valid_i | input | 1 | Read data valid, completes the request |
| mon_en_o | output | 1 | Enter monitor mode |
| pll_en_o | output | 1 | Enable PLL clock multiplication |
| cop_dis_o | output | 1 | Disable the watchdog |
| portb_chk_o | output | 1 | Enable port-B entry-pin checking |
| sec_rst_o | output | 1 | Secondary internal reset request |

## Verification
The assertions take for granted that `mem_valid_i` comes only while `mem_req_o` is high and lasts a single cycle. They also take for granted that the pin levels and flags are stable across reset release until the snapshot, which happens SYNC_STAGES+1 cycles later. The bench drives the read port from a responder that answers only open requests, with a random delay of 0 to 3 cycles, and drops valid on the next cycle. It holds all pins from before reset release for ten cycles, and only after that randomizes them to probe the latched mode and the watchdog behaviour.

// File: rtl/mon_entry_pkg.sv
package mon_entry_pkg;

  typedef enum logic [1:0] {
    MODE_NONE      = 2'd0,
    MODE_HV        = 2'd1,
    MODE_BLANK_PU  = 2'd2,
    MODE_BLANK_PLL = 2'd3
  } mon_mode_e;

  typedef enum logic [2:0] {
    ST_WAIT   = 3'd0,
    ST_RD_HI  = 3'd1,
    ST_RD_LO  = 3'd2,
    ST_DECIDE = 3'd3,
    ST_SECRST = 3'd4,
    ST_RUN    = 3'd5
  } seq_state_e;

  // Entry decision: high voltage on IRQ wins; otherwise a blank vector
  // enters, with the PLL chosen by a low IRQ level.
  function automatic mon_mode_e classify(input logic hv_irq,
                                         input logic irq_high,
                                         input logic blank);
    if (hv_irq)        return MODE_HV;
    else if (!blank)   return MODE_NONE;
    else if (irq_high) return MODE_BLANK_PU;
    else               return MODE_BLANK_PLL;
  endfunction

  function automatic logic mode_is_blank_entry(input mon_mode_e m);
    return (m == MODE_BLANK_PU) || (m == MODE_BLANK_PLL);
  endfunction

  function automatic logic watchdog_off(input mon_mode_e m,
                                        input logic hv_irq_live,
                                        input logic hv_rst_live);
    if (mode_is_blank_entry(m)) return 1'b1;
    if (m == MODE_HV)           return hv_irq_live | hv_rst_live;
    return 1'b0;
  endfunction

endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mon_seq.sv
module mon_seq
  import mon_entry_pkg::*;
#(
  parameter int              ADDR_W         = 16,
  parameter int              DATA_W         = 8,
  parameter int              SYNC_STAGES    = 2,
  parameter int              SEC_RST_CYCLES = 4,
  parameter logic [ADDR_W-1:0] VEC_HI_ADDR  = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_valid_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              want_sec_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              sample_evt_o,
  output logic              decide_evt_o,
  output logic [DATA_W-1:0] hi_byte_o,
  output logic [DATA_W-1:0] lo_byte_o,
  output logic              sec_rst_o
);
  localparam int MAXC = (SYNC_STAGES > SEC_RST_CYCLES) ? SYNC_STAGES : SEC_RST_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [ADDR_W-1:0] VEC_LO_ADDR = VEC_HI_ADDR + 1'b1;

  seq_state_e    state;
  logic [CW-1:0] cnt;

  assign sample_evt_o = (state == ST_WAIT) && (cnt == CW'(SYNC_STAGES));
  assign decide_evt_o = (state == ST_DECIDE);
  assign mem_req_o    = (state == ST_RD_HI) || (state == ST_RD_LO);
  assign mem_addr_o   = (state == ST_RD_LO) ? VEC_LO_ADDR : VEC_HI_ADDR;
  assign sec_rst_o    = (state == ST_SECRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT;
      cnt       <= '0;
      hi_byte_o <= '0;
      lo_byte_o <= '0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (sample_evt_o) begin
            state <= ST_RD_HI;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RD_HI: if (mem_valid_i) begin
          hi_byte_o <= mem_data_i;
          state     <= ST_RD_LO;
        end
        ST_RD_LO: if (mem_valid_i) begin
          lo_byte_o <= mem_data_i;
          state     <= ST_DECIDE;
        end
        ST_DECIDE: begin
          cnt   <= '0;
          state <= want_sec_i ? ST_SECRST : ST_RUN;
        end
        ST_SECRST: begin
          if (cnt == CW'(SEC_RST_CYCLES - 1)) state <= ST_RUN;
          else                                cnt   <= cnt + 1'b1;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  // R1: an open request keeps its address until it is answered
  a_r1_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_valid_i |=> mem_req_o && $stable(mem_addr_o));

  // R1: the low byte is only read right after the high byte completed
  a_r1_hi_before_lo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_addr_o == VEC_LO_ADDR) |-> $past(mem_valid_i));
endmodule

// File: rtl/mon_decide.sv
module mon_decide
  import mon_entry_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_evt_i,
  input  logic              decide_evt_i,
  input  logic              irq_lvl_s_i,
  input  logic              irq_hv_s_i,
  input  logic              rst_hv_s_i,
  input  logic [DATA_W-1:0] hi_byte_i,
  input  logic [DATA_W-1:0] lo_byte_i,
  output logic              want_sec_o,
  output logic              mon_en_o,
  output logic              pll_en_o,
  output logic              cop_dis_o,
  output logic              portb_chk_o
);
  logic      irq_lvl_q, hv_snap_q;
  logic      mode_valid_q, blank_q;
  mon_mode_e mode_q, mode_calc;
  logic      blank_w;

  assign blank_w    = (&hi_byte_i) & (&lo_byte_i);
  assign mode_calc  = classify(hv_snap_q, irq_lvl_q, blank_w);
  assign want_sec_o = mode_is_blank_entry(mode_calc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_lvl_q    <= 1'b0;
      hv_snap_q    <= 1'b0;
      mode_valid_q <= 1'b0;
      blank_q      <= 1'b0;
      mode_q       <= MODE_NONE;
    end else begin
      if (sample_evt_i) begin
        irq_lvl_q <= irq_lvl_s_i;
        hv_snap_q <= irq_hv_s_i;
      end
      if (decide_evt_i && !mode_valid_q) begin
        mode_q       <= mode_calc;
        blank_q      <= blank_w;
        mode_valid_q <= 1'b1;
      end
    end
  end

  assign mon_en_o    = mode_valid_q && (mode_q != MODE_NONE);
  assign pll_en_o    = mode_valid_q && (mode_q == MODE_BLANK_PLL);
  assign portb_chk_o = mode_valid_q && (mode_q == MODE_HV);
  assign cop_dis_o   = mode_valid_q && watchdog_off(mode_q, irq_hv_s_i, rst_hv_s_i);

  // R10: once taken, the decision never changes
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid_q && $past(mode_valid_q) |-> $stable(mode_q));

  // R6: PLL only ever runs with a blank vector
  a_r6_pll_needs_blank: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en_o |-> blank_q && !hv_snap_q);

  // R8: blank-vector entry keeps the watchdog off
  a_r8_cop_blank: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid_q && blank_q && !hv_snap_q |-> cop_dis_o);

  // R3: high-voltage entry checks port B and leaves the PLL off
  a_r3_hv_entry: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid_q && hv_snap_q |-> mon_en_o && portb_chk_o && !pll_en_o);
endmodule

// File: rtl/mon_entry_ctrl.sv
module mon_entry_ctrl
  import mon_entry_pkg::*;
#(
  parameter int                ADDR_W         = 16,
  parameter int                DATA_W         = 8,
  parameter int                SYNC_STAGES    = 2,
  parameter int                SEC_RST_CYCLES = 4,
  parameter logic [ADDR_W-1:0] VEC_HI_ADDR    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              irq_pin_i,
  input  logic              irq_hv_i,
  input  logic              rst_hv_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              mem_valid_i,
  output logic              mon_en_o,
  output logic              pll_en_o,
  output logic              cop_dis_o,
  output logic              portb_chk_o,
  output logic              sec_rst_o
);
  logic [2:0]        pins_s;
  logic              sample_evt, decide_evt, want_sec;
  logic [DATA_W-1:0] hi_byte, lo_byte;

  mon_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     ({rst_hv_i, irq_hv_i, irq_pin_i}),
    .q     (pins_s)
  );

  mon_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
    .SEC_RST_CYCLES(SEC_RST_CYCLES), .VEC_HI_ADDR(VEC_HI_ADDR)
  ) i_seq (
    .clk          (clk),
    .rst_n        (por_n),
    .mem_valid_i  (mem_valid_i),
    .mem_data_i   (mem_data_i),
    .want_sec_i   (want_sec),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .sample_evt_o (sample_evt),
    .decide_evt_o (decide_evt),
    .hi_byte_o    (hi_byte),
    .lo_byte_o    (lo_byte),
    .sec_rst_o    (sec_rst_o)
  );

  mon_decide #(.DATA_W(DATA_W)) i_decide (
    .clk          (clk),
    .rst_n        (por_n),
    .sample_evt_i (sample_evt),
    .decide_evt_i (decide_evt),
    .irq_lvl_s_i  (pins_s[0]),
    .irq_hv_s_i   (pins_s[1]),
    .rst_hv_s_i   (pins_s[2]),
    .hi_byte_i    (hi_byte),
    .lo_byte_i    (lo_byte),
    .want_sec_o   (want_sec),
    .mon_en_o     (mon_en_o),
    .pll_en_o     (pll_en_o),
    .cop_dis_o    (cop_dis_o),
    .portb_chk_o  (portb_chk_o)
  );

  // R7: the secondary reset only follows a blank-vector monitor entry
  a_r7_sec_after_blank: assert property (@(posedge clk) disable iff (!por_n)
    sec_rst_o |-> mon_en_o && !portb_chk_o && cop_dis_o);

  // R1: no read is issued while the secondary reset is requested
  a_r1_quiet_in_secrst: assert property (@(posedge clk) disable iff (!por_n)
    sec_rst_o |-> !mem_req_o);
endmodule

// File: tb/test_mon_entry_ctrl.sv
module test_mon_entry_ctrl;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        irq_pin = 1'b1, irq_hv = 1'b0, rst_hv = 1'b0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data = 8'h00;
  logic        mem_valid = 1'b0;
  logic        mon_en, pll_en, cop_dis, portb_chk, sec_rst;

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0]  vec_hi = 8'hFF, vec_lo = 8'hFF;
  int          rd_cnt = 0;
  logic [15:0] addr_log [2];
  int          sec_cycles = 0, sec_pulses = 0;
  logic        sec_prev = 1'b0;

  always #5 clk = ~clk;

  mon_entry_ctrl i_mon_entry_ctrl (
    .clk(clk), .por_n(por_n), .irq_pin_i(irq_pin), .irq_hv_i(irq_hv),
    .rst_hv_i(rst_hv), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .mem_valid_i(mem_valid), .mon_en_o(mon_en),
    .pll_en_o(pll_en), .cop_dis_o(cop_dis), .portb_chk_o(portb_chk),
    .sec_rst_o(sec_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected entry class: 0 none, 1 high voltage, 2 blank/IRQ high, 3 blank/IRQ low
  function automatic int exp_class(input logic hv, input logic irq, input logic [7:0] hi, input logic [7:0] lo);
    logic empty;
    empty = (hi == 8'hFF) && (lo == 8'hFF);
    if (hv == 1'b1) return 1;
    if (!empty)     return 0;
    return irq ? 2 : 3;
  endfunction

  // read responder and monitors
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (mem_valid) mem_valid = 1'b0;
      else if (por_n && mem_req) begin
        if (dly == 0) begin
          if (rd_cnt < 2) addr_log[rd_cnt] = mem_addr;
          rd_cnt++;
          mem_data  = (mem_addr == 16'hFFFE) ? vec_hi :
                      (mem_addr == 16'hFFFF) ? vec_lo : 8'h5A;
          mem_valid = 1'b1;
          dly = $urandom % 4;
        end else dly--;
      end
    end
  end

  always @(negedge clk) begin
    if (sec_rst) sec_cycles++;
    if (sec_rst && !sec_prev) sec_pulses++;
    sec_prev <= sec_rst;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_trial(input logic hv, input logic irq, input logic rhv,
                           input logic [7:0] hi, input logic [7:0] lo);
    int cls;
    logic m0, p0, b0;
    cls = exp_class(hv, irq, hi, lo);
    @(negedge clk);
    por_n = 1'b0;
    irq_hv = hv; irq_pin = irq; rst_hv = rhv;
    vec_hi = hi; vec_lo = lo;
    repeat (2) @(negedge clk);
    check("R11 reset outputs", {27'd0, mon_en, pll_en, cop_dis, portb_chk, sec_rst}, 32'd0);
    rd_cnt = 0; sec_cycles = 0; sec_pulses = 0;
    addr_log[0] = 16'h0; addr_log[1] = 16'h0;
    por_n = 1'b1;
    @(negedge clk);
    check("R11 pre-decision outputs", {27'd0, mon_en, pll_en, cop_dis, portb_chk, sec_rst}, 32'd0);
    repeat (9) @(negedge clk);
    // pins held across the snapshot; now leave them alone until settled
    repeat (30) @(negedge clk);
    check("R1 read count", rd_cnt, 2);
    check("R1 first address", addr_log[0], 16'hFFFE);
    check("R1 second address", addr_log[1], 16'hFFFF);
    check("R1 no request after decision", mem_req, 1'b0);
    case (cls)
      0: begin
        check("R6 mon_en", mon_en, 0); check("R6 pll_en", pll_en, 0);
        check("R6 cop_dis", cop_dis, 0); check("R6 portb", portb_chk, 0);
        check("R6 no secondary reset", sec_pulses, 0);
      end
      1: begin
        check("R3 mon_en", mon_en, 1); check("R3 pll_en", pll_en, 0);
        check("R3 portb", portb_chk, 1); check("R3 no secondary reset", sec_pulses, 0);
        check("R9 cop follows flags", cop_dis, hv | rhv);
      end
      2: begin
        check("R4 mon_en", mon_en, 1); check("R4 pll_en", pll_en, 0);
        check("R4 portb", portb_chk, 0); check("R8 cop_dis", cop_dis, 1);
        check("R7 pulse count", sec_pulses, 1); check("R7 pulse length", sec_cycles, 4);
      end
      default: begin
        check("R5 mon_en", mon_en, 1); check("R5 pll_en", pll_en, 1);
        check("R5 portb", portb_chk, 0); check("R8 cop_dis", cop_dis, 1);
        check("R7 pulse count", sec_pulses, 1); check("R7 pulse length", sec_cycles, 4);
      end
    endcase
    if ((hi == 8'hFF) != (lo == 8'hFF) && !hv)
      check("R2 single blank byte is not blank", mon_en, 0);
    // R10 / R8 / R9: disturb the pins after the decision
    m0 = mon_en; p0 = pll_en; b0 = portb_chk;
    for (int k = 0; k < 3; k++) begin
      irq_pin = 1'($urandom); irq_hv = 1'($urandom); rst_hv = 1'($urandom);
      repeat (4) @(negedge clk);
      check("R10 mode held", {29'd0, mon_en, pll_en, portb_chk}, {29'd0, m0, p0, b0});
      if (cls == 1)      check("R9 cop live", cop_dis, irq_hv | rst_hv);
      else if (cls == 0) check("R6 cop stays on", cop_dis, 0);
      else               check("R8 cop ignores pins", cop_dis, 1);
    end
    check("R7 no further pulse", sec_pulses, (cls >= 2) ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    // directed corners
    run_trial(1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF);   // R4
    run_trial(1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);   // R5
    run_trial(1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF);   // R3 wins over blank
    run_trial(1'b1, 1'b1, 1'b0, 8'h12, 8'h34);   // R3 non-blank
    run_trial(1'b0, 1'b0, 1'b0, 8'hFF, 8'hFE);   // R2
    run_trial(1'b0, 1'b1, 1'b0, 8'h7F, 8'hFF);   // R2
    run_trial(1'b0, 1'b0, 1'b1, 8'h00, 8'h00);   // R6 with RST high voltage

    // R9 directed: move high voltage from IRQ to RST, then remove it
    run_trial(1'b1, 1'b1, 1'b0, 8'hAB, 8'hCD);
    irq_hv = 1'b1; rst_hv = 1'b0; repeat (4) @(negedge clk);
    check("R9 cop with IRQ high voltage", cop_dis, 1);
    rst_hv = 1'b1; repeat (4) @(negedge clk);
    irq_hv = 1'b0; repeat (4) @(negedge clk);
    check("R9 cop held by RST high voltage", cop_dis, 1);
    rst_hv = 1'b0; repeat (4) @(negedge clk);
    check("R9 cop released", cop_dis, 0);
    check("R10 mon_en kept", mon_en, 1);

    // constrained random trials
    for (int t = 0; t < 24; t++) begin
      logic [7:0] h, l;
      h = ($urandom % 2) ? 8'hFF : 8'($urandom);
      l = ($urandom % 2) ? 8'hFF : 8'($urandom);
      run_trial(($urandom % 4) == 0, 1'($urandom), 1'($urandom), h, l);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule